// File: doc/BRIEF.md
# Halt-Loop Manual Operation Sequencer

This block is the idle sequence a stopped processor runs while it waits for an operator. It steps through four states in a fixed ring. In step one it captures the operator panel request code and drops the stop trigger, so pending external or channel interrupts can be serviced. Steps two and three look for a manual operation in the captured code and hand control to that operation. Step four is reached only when nothing was requested. It raises the stop trigger again and either goes round once more, if the exception line is still high, or leaves for instruction fetch.

A handed-off operation is shown on a one-hot dispatch vector. The vector stays asserted until the operation's handler pulses done, and the sequencer then goes back to step one. Leaving through step four pulses an exit strobe. In that same cycle the exit strobe presents the protect key taken from the upper PSW half and the instruction address to be loaded into the storage address register. Outside the loop the sequencer waits in a run state. At each instruction boundary it re-enters step one if the exception line is high, or if the address-compare switch asks for one pass per instruction.

Top module: `halt_loop_seq`

## Requirements
- R1: During reset the loop state reads step one (code 1), the stop trigger is on, and dispatch, exit and interrupt-take are all low.
- R2: Loop state codes are run=0, step1=1, step2=2, step3=3, step4=4, operation=5. With no request and the exception line high, the state visits 1,2,3,4 in order and repeats. Stop-clear pulses in step one and stop-set pulses in step four, never both in one cycle.
- R3: Step one captures the panel code. If an external or channel interrupt is pending there, interrupt-take pulses and the state goes to run without any dispatch.
- R4: Codes 1 (instruction step), 2 (set IC), 3 (repeat instruction) and 4 (address compare) dispatch from step two. The dispatch is visible two cycles after the step-one cycle. Codes 5 (main storage), 6 (protection key), 7 (local storage) and 8 (bump storage) dispatch from step three, three cycles after step one.
- R5: Code 0 and codes 9 to 15 dispatch nothing, and the pass proceeds to step four.
- R6: Code k drives dispatch bit k-1 alone. The bit holds, with the state at operation, until op_done_i is seen. The next state is then step one.
- R7: Any dispatch except instruction step pulses stop-set in its dispatch cycle, and the stop trigger stays on during the operation. Instruction step leaves the trigger off.
- R8: At step four, a high exception line returns the state to step one. A low exception line pulses exit_o with key_o equal to psw_i and sar_o equal to iar_i, and the state goes to run.
- R9: In the run state, instr_end_i with either exception_i or acmp_i high enters step one on the next cycle. Otherwise the state stays at run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| panel_req_i | input | CODE_W | Panel manual request code |
| exception_i | input | 1 | Exception line, 1 keeps the processor stopped |
| ext_irq_i | input | 1 | External interrupt pending |
| chan_irq_i | input | 1 | Channel interrupt pending |
| instr_end_i | input | 1 | Instruction boundary strobe while running |
| acmp_i | input | 1 | Address-compare mode active |
| op_done_i | input | 1 | Dispatched operation finished |
| psw_i | input | PSW_W | Upper PSW half holding the protect key |
| iar_i | input | ADDR_W | Instruction address register |
| loop_state_o | output | 3 | Current loop state code |
| stop_set_o | output | 1 | Stop trigger set pulse |
| stop_clr_o | output | 1 | Stop trigger clear pulse |
| stop_trig_o | output | 1 | Stop trigger level |
| op_dispatch_o | output | NUM_OPS | One-hot manual operation dispatch |
| irq_take_o | output | 1 | Interrupt accepted at step one |
| exit_o | output | 1 | Leave toward instruction fetch |
| key_o | output | PSW_W | Protect key to restore, valid with exit_o |
| sar_o | output | ADDR_W | Storage address to load, valid with exit_o |

## Verification
A wrong state register shows up at once in the ordering of stop-clear and stop-set pulses, or in a dispatch that lands one cycle early or late. The bench compares that ordering event by event and checks dispatch latency to the cycle. A stop trigger left in the wrong level is exposed while an operation is held, and an exit from the wrong step shows as a missing or extra exit strobe carrying the restore values. Both show within one loop pass, at most five cycles after the stimulus.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [2:0] {
    ST_RUN = 3'd0,
    ST_S1  = 3'd1,
    ST_S2  = 3'd2,
    ST_S3  = 3'd3,
    ST_S4  = 3'd4,
    ST_OP  = 3'd5
  } loop_st_e;

  localparam int unsigned ISTEP_BIT = 0;
endpackage

// File: rtl/hl_status_decode.sv
module hl_status_decode #(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned NUM_OPS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_i,
  input  logic [CODE_W-1:0]  panel_req_i,
  output logic [NUM_OPS-1:0] op_oh_o,
  output logic               grp_lo_hit_o,
  output logic               grp_hi_hit_o
);
  localparam int unsigned LO_N = NUM_OPS / 2;

  logic [CODE_W-1:0] status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_q <= '0;
    else if (latch_i) status_q <= panel_req_i;
  end

  // code k selects op k-1; 0 and out-of-range codes select nothing
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_dec
    assign op_oh_o[i] = (status_q == CODE_W'(i + 1));
  end

  assign grp_lo_hit_o = |op_oh_o[LO_N-1:0];
  assign grp_hi_hit_o = |op_oh_o[NUM_OPS-1:LO_N];

  assert_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> status_q == $past(panel_req_i));
  assert_dec_group_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grp_lo_hit_o && grp_hi_hit_o));
endmodule

// File: rtl/hl_step_fsm.sv
module hl_step_fsm
  import halt_pkg::*;
#(
  parameter int unsigned NUM_OPS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_pend_i,
  input  logic               exception_i,
  input  logic               instr_end_i,
  input  logic               acmp_i,
  input  logic               op_done_i,
  input  logic [NUM_OPS-1:0] op_oh_i,
  input  logic               grp_lo_hit_i,
  input  logic               grp_hi_hit_i,
  output logic               latch_o,
  output logic [2:0]         state_o,
  output logic               stop_set_o,
  output logic               stop_clr_o,
  output logic               stop_trig_o,
  output logic [NUM_OPS-1:0] dispatch_o,
  output logic               irq_take_o,
  output logic               exit_o
);
  loop_st_e state_q, state_d;
  logic [NUM_OPS-1:0] disp_q;
  logic stop_q;
  logic take_op;

  always_comb begin
    state_d    = state_q;
    latch_o    = 1'b0;
    stop_set_o = 1'b0;
    stop_clr_o = 1'b0;
    irq_take_o = 1'b0;
    exit_o     = 1'b0;
    take_op    = 1'b0;
    unique case (state_q)
      ST_RUN: if (instr_end_i && (exception_i || acmp_i)) state_d = ST_S1;
      ST_S1: begin
        latch_o    = 1'b1;
        stop_clr_o = 1'b1;
        if (irq_pend_i) begin
          irq_take_o = 1'b1;
          state_d    = ST_RUN;
        end else begin
          state_d = ST_S2;
        end
      end
      ST_S2: begin
        if (grp_lo_hit_i) begin
          take_op    = 1'b1;
          stop_set_o = !op_oh_i[ISTEP_BIT];
          state_d    = ST_OP;
        end else begin
          state_d = ST_S3;
        end
      end
      ST_S3: begin
        if (grp_hi_hit_i) begin
          take_op    = 1'b1;
          stop_set_o = !op_oh_i[ISTEP_BIT];
          state_d    = ST_OP;
        end else begin
          state_d = ST_S4;
        end
      end
      ST_S4: begin
        stop_set_o = 1'b1;
        if (exception_i) begin
          state_d = ST_S1;
        end else begin
          exit_o  = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_OP: if (op_done_i) state_d = ST_S1;
      default: state_d = ST_S1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_S1;
      disp_q  <= '0;
      stop_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (take_op)                            disp_q <= op_oh_i;
      else if (state_q == ST_OP && op_done_i) disp_q <= '0;
      if (stop_set_o)      stop_q <= 1'b1;
      else if (stop_clr_o) stop_q <= 1'b0;
    end
  end

  assign state_o     = state_q;
  assign dispatch_o  = disp_q;
  assign stop_trig_o = stop_q;

  assert_stop_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_set_o && stop_clr_o));
  assert_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_S3) |-> $past(state_q) == ST_S2);
  assert_irq_leave_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> (state_q == ST_RUN) && (disp_q == '0));
  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_q));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OP && !op_done_i) |=> $stable(disp_q) && state_q == ST_OP);
  assert_istep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OP && disp_q[ISTEP_BIT]) |-> !stop_q);
  assert_guard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OP && disp_q != '0 && !disp_q[ISTEP_BIT]) |-> stop_q);
  assert_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> state_q == ST_RUN && stop_q);
  assert_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !instr_end_i) |=> state_q == ST_RUN);
endmodule

// File: rtl/halt_loop_seq.sv
module halt_loop_seq #(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned NUM_OPS = 8,
  parameter int unsigned PSW_W   = 16,
  parameter int unsigned ADDR_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CODE_W-1:0]  panel_req_i,
  input  logic               exception_i,
  input  logic               ext_irq_i,
  input  logic               chan_irq_i,
  input  logic               instr_end_i,
  input  logic               acmp_i,
  input  logic               op_done_i,
  input  logic [PSW_W-1:0]   psw_i,
  input  logic [ADDR_W-1:0]  iar_i,
  output logic [2:0]         loop_state_o,
  output logic               stop_set_o,
  output logic               stop_clr_o,
  output logic               stop_trig_o,
  output logic [NUM_OPS-1:0] op_dispatch_o,
  output logic               irq_take_o,
  output logic               exit_o,
  output logic [PSW_W-1:0]   key_o,
  output logic [ADDR_W-1:0]  sar_o
);
  logic               latch;
  logic [NUM_OPS-1:0] op_oh;
  logic               grp_lo_hit, grp_hi_hit;

  hl_status_decode #(.CODE_W(CODE_W), .NUM_OPS(NUM_OPS)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .latch_i      (latch),
    .panel_req_i  (panel_req_i),
    .op_oh_o      (op_oh),
    .grp_lo_hit_o (grp_lo_hit),
    .grp_hi_hit_o (grp_hi_hit)
  );

  hl_step_fsm #(.NUM_OPS(NUM_OPS)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_pend_i   (ext_irq_i | chan_irq_i),
    .exception_i  (exception_i),
    .instr_end_i  (instr_end_i),
    .acmp_i       (acmp_i),
    .op_done_i    (op_done_i),
    .op_oh_i      (op_oh),
    .grp_lo_hit_i (grp_lo_hit),
    .grp_hi_hit_i (grp_hi_hit),
    .latch_o      (latch),
    .state_o      (loop_state_o),
    .stop_set_o   (stop_set_o),
    .stop_clr_o   (stop_clr_o),
    .stop_trig_o  (stop_trig_o),
    .dispatch_o   (op_dispatch_o),
    .irq_take_o   (irq_take_o),
    .exit_o       (exit_o)
  );

  // restore values only presented alongside the exit strobe
  assign key_o = exit_o ? psw_i : '0;
  assign sar_o = exit_o ? iar_i : '0;

  assert_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> !exception_i && !(ext_irq_i && irq_take_o));
endmodule

// File: tb/sim_halt_loop_seq.sv
`timescale 1ns/1ps
module sim_halt_loop_seq;
  localparam int CODE_W = 4, NUM_OPS = 8, PSW_W = 16, ADDR_W = 24;
  localparam int K_CLR = 1, K_IRQ = 2, K_DISP = 3, K_SET = 4, K_EXIT = 5;

  typedef struct packed {
    logic [3:0]  kind;
    logic [7:0]  code;
    logic [15:0] key;
    logic [23:0] sar;
  } ev_t;

  logic clk_i = 0, rst_ni = 0;
  logic [CODE_W-1:0] panel_req_i = '0;
  logic exception_i = 1, ext_irq_i = 0, chan_irq_i = 0, instr_end_i = 0, acmp_i = 0, op_done_i = 0;
  logic [PSW_W-1:0] psw_i = '0;
  logic [ADDR_W-1:0] iar_i = '0;
  logic [2:0] loop_state_o;
  logic stop_set_o, stop_clr_o, stop_trig_o, irq_take_o, exit_o;
  logic [NUM_OPS-1:0] op_dispatch_o;
  logic [PSW_W-1:0] key_o;
  logic [ADDR_W-1:0] sar_o;

  int checks = 0, errors = 0;
  ev_t   exp_q[$];
  string req_q[$];
  logic [NUM_OPS-1:0] prev_disp = '0;

  always #2 clk_i = ~clk_i;

  halt_loop_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic ev_t mk(input int k, input int c, input logic [15:0] ky, input logic [23:0] sa);
    ev_t e;
    e.kind = 4'(k); e.code = 8'(c); e.key = ky; e.sar = sa;
    return e;
  endfunction

  task automatic push(input ev_t e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic got(input ev_t e);
    ev_t x;
    string r;
    if (exp_q.size() == 0) begin
      chk(0, "unexpected event", 64'(e), 64'(0));
    end else begin
      x = exp_q.pop_front();
      r = req_q.pop_front();
      chk(x == e, r, 64'(e), 64'(x));
    end
  endtask

  // monitor: event order scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni) begin
        if (stop_clr_o) got(mk(K_CLR, 0, 0, 0));
        if (irq_take_o) got(mk(K_IRQ, 0, 0, 0));
        if (op_dispatch_o != '0 && prev_disp == '0) begin
          int c = 0;
          for (int i = 0; i < NUM_OPS; i++) if (op_dispatch_o[i]) c = i + 1;
          got(mk(K_DISP, c, 0, 0));
        end
        if (stop_set_o) got(mk(K_SET, 0, 0, 0));
        if (exit_o) got(mk(K_EXIT, 0, key_o, sar_o));
      end
      prev_disp = op_dispatch_o;
    end
  end

  // one loop pass starting at a step-one cycle
  task automatic pass(input int code, input bit exc, input bit ext, input bit chn);
    int n = 0;
    int lat = -1;
    bit dispatch;
    while (loop_state_o != 3'd1) @(negedge clk_i);
    panel_req_i = CODE_W'(code);
    exception_i = exc;
    ext_irq_i   = ext;
    chan_irq_i  = chn;
    dispatch = (code >= 1 && code <= 8);
    push(mk(K_CLR, 0, 0, 0), "R3 step1 clear");
    if (ext || chn) begin
      push(mk(K_IRQ, 0, 0, 0), "R3 irq take");
    end else if (dispatch) begin
      if (code != 1) push(mk(K_SET, 0, 0, 0), "R7 dispatch sets stop");
      push(mk(K_DISP, code, 0, 0), "R4 dispatch code");
    end else begin
      push(mk(K_SET, 0, 0, 0), (code == 0) ? "R2 step4 set" : "R5 unknown code");
      if (!exc) push(mk(K_EXIT, 0, psw_i, iar_i), "R8 exit restore");
    end
    do begin
      @(negedge clk_i);
      n++;
      if (lat < 0 && op_dispatch_o != '0) lat = n;
    end while (!(exp_q.size() == 0 && loop_state_o inside {3'd0, 3'd1, 3'd5}) && n < 40);
    chk(exp_q.size() == 0, "pass completion", 64'(exp_q.size()), 64'(0));
    if (dispatch && !(ext || chn))
      chk(lat == ((code <= 4) ? 2 : 3), "R4 dispatch step latency", 64'(lat), 64'((code <= 4) ? 2 : 3));
    ext_irq_i = 0;
    chan_irq_i = 0;
  endtask

  task automatic finish_op();
    op_done_i = 1;
    @(negedge clk_i);
    op_done_i = 0;
    chk(loop_state_o == 3'd1 && op_dispatch_o == '0, "R6 return to step1", 64'(loop_state_o), 64'(1));
  endtask

  task automatic boundary(input bit exc, input bit ac, input bit expect_enter);
    instr_end_i = 1;
    exception_i = exc;
    acmp_i = ac;
    @(negedge clk_i);
    instr_end_i = 0;
    acmp_i = 0;
    chk(loop_state_o == (expect_enter ? 3'd1 : 3'd0), "R9 run boundary", 64'(loop_state_o), 64'(expect_enter ? 1 : 0));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk_i);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(loop_state_o == 3'd1, "R1 reset state", 64'(loop_state_o), 64'(1));
    chk(stop_trig_o == 1'b1, "R1 reset stop trigger", 64'(stop_trig_o), 64'(1));
    chk(op_dispatch_o == '0 && !exit_o && !irq_take_o, "R1 reset outputs", 64'({op_dispatch_o, exit_o, irq_take_o}), 64'(0));
    rst_ni = 1;

    // R2 idle loop with exception held
    pass(0, 1, 0, 0);
    chk(loop_state_o == 3'd1, "R2 loop repeats", 64'(loop_state_o), 64'(1));
    pass(0, 1, 0, 0);
    // R5 unknown codes
    pass(9, 1, 0, 0);
    pass(15, 1, 0, 0);
    chk(op_dispatch_o == '0, "R5 no dispatch", 64'(op_dispatch_o), 64'(0));

    // R6/R7 main storage display held until done
    pass(5, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      chk(loop_state_o == 3'd5 && op_dispatch_o == 8'h10, "R6 dispatch held", 64'({loop_state_o, op_dispatch_o}), 64'({3'd5, 8'h10}));
      chk(stop_trig_o == 1'b1, "R7 stop on during op", 64'(stop_trig_o), 64'(1));
      @(negedge clk_i);
    end
    finish_op();

    // R7 instruction step leaves trigger off
    pass(1, 1, 0, 0);
    chk(op_dispatch_o == 8'h01, "R6 istep bit", 64'(op_dispatch_o), 64'(1));
    chk(stop_trig_o == 1'b0, "R7 istep trigger off", 64'(stop_trig_o), 64'(0));
    finish_op();

    // R4 group boundaries
    pass(4, 1, 0, 0);
    chk(op_dispatch_o == 8'h08, "R4 code4 bit", 64'(op_dispatch_o), 64'(8));
    finish_op();
    pass(8, 1, 0, 0);
    chk(op_dispatch_o == 8'h80, "R4 code8 bit", 64'(op_dispatch_o), 64'(8'h80));
    finish_op();
    pass(2, 1, 0, 0);
    finish_op();

    // R3 external interrupt preempts decode
    pass(5, 1, 1, 0);
    chk(loop_state_o == 3'd0 && op_dispatch_o == '0, "R3 irq to run", 64'(loop_state_o), 64'(0));
    chk(stop_trig_o == 1'b0, "R3 trigger open", 64'(stop_trig_o), 64'(0));
    boundary(0, 0, 0);
    boundary(1, 0, 1);

    // R3 channel interrupt
    pass(0, 1, 0, 1);
    chk(loop_state_o == 3'd0, "R3 chan irq to run", 64'(loop_state_o), 64'(0));
    boundary(1, 0, 1);

    // R8 exit with restore values
    psw_i = 16'hA5C3;
    iar_i = 24'h123456;
    pass(0, 0, 0, 0);
    chk(loop_state_o == 3'd0, "R8 exit to run", 64'(loop_state_o), 64'(0));

    // R9 address compare forces one pass per instruction
    psw_i = 16'h0F1E;
    iar_i = 24'hABCDE0;
    boundary(0, 1, 1);
    pass(0, 0, 0, 0);
    chk(loop_state_o == 3'd0, "R9 single forced pass", 64'(loop_state_o), 64'(0));
    boundary(0, 0, 0);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "final queue", 64'(exp_q.size()), 64'(0));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule